// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block is the host side of an erase operation on a serial flash attached over a four-wire SPI link. A single request names the region to clear, either a small 4 KByte sector or a large 32 KByte block, together with any byte address inside that region. The block then runs the full exchange without further help and reports when the flash is ready again.

Each operation uses three kinds of chip-select frame. The first frame unlocks the device for writing. The second frame carries the erase opcode and the region address. Chip select then rises, and the flash starts its internal erase. After that, the block reads the status register again and again until the ready indication appears. If the flash stays busy for too many reads, the operation ends with a timeout flag instead. The serial clock is derived from the system clock by a parameterised divider and idles low.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, flash_cs_n is 1, flash_sck is 0, and busy, done and timeout are all 0.
- R2: An accepted start opens a chip-select frame on the next clock: busy is 1 and flash_cs_n is 0. That first frame is 8 bits long and carries 8'h06, MSB first.
- R3: The second frame is 32 bits long. It holds an opcode byte followed by a 24-bit address, MSB first. The opcode is 8'h20 when erase_big is 0 and 8'h52 when erase_big is 1. The address is erase_addr with bits [11:0] cleared for the small erase, or with bits [14:0] cleared for the large erase.
- R4: Each status read is a 16-bit frame. The block sends 8'h05 followed by eight 0 bits, and it takes flash_miso on the eight rising edges that follow the opcode, MSB first. The last bit taken (status bit 0) is the busy flag, where 1 means busy.
- R5: Status reads repeat until a read returns busy = 0. The block then pulses done, busy falls in the same cycle, and no further frame is sent.
- R6: flash_sck is 0 whenever flash_cs_n is 1. Between two frames of one operation, flash_cs_n stays high for at least 2*GAP_SCK*HALF_DIV clocks.
- R7: Serial clock in mode 0: each half period of flash_sck lasts HALF_DIV system clocks. flash_mosi changes only while flash_sck is low, so the flash samples it on rising edges.
- R8: A start that arrives while busy is 1 has no effect. The frames, the address and the number of reads are those of the operation already running, and no extra frame follows done.
- R9: If POLL_LIMIT status reads in a row all return busy = 1, the operation ends with timeout = 1 and a done pulse. timeout stays 1 until the next accepted start clears it.
- R10: done is high for exactly one system clock per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an erase; sampled only while idle |
| erase_big | input | 1 | 0 = 4 KByte sector erase, 1 = 32 KByte block erase |
| erase_addr | input | 24 | Any byte address inside the region to erase |
| flash_sck | output | 1 | Serial clock to the flash |
| flash_cs_n | output | 1 | Active-low chip select |
| flash_mosi | output | 1 | Serial data to the flash |
| flash_miso | input | 1 | Serial data from the flash |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-clock pulse at the end of an operation |
| timeout | output | 1 | Last operation ended without the flash becoming ready |

## Verification
Most internal faults here show up at the serial pins within one frame. A wrong phase or shift register sends the wrong opcode, the wrong address bits or the wrong frame length. The bench flash model records each of these when chip select rises and compares it against the expected frame. A wrong bit count or read decision shows up as one status frame too many or too few, or as done arriving early or late, by the end of the operation. A start that was not ignored shows up as an extra frame within a few dozen clocks after done.

// File: rtl/flash_erase_seq.sv
`timescale 1ns/1ps
module flash_erase_seq #(
  parameter int HALF_DIV    = 2,
  parameter int GAP_SCK     = 2,
  parameter int POLL_LIMIT  = 8,
  parameter int SECTOR_LOG2 = 12,
  parameter int BLOCK_LOG2  = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        erase_big,
  input  logic [23:0] erase_addr,
  output logic        flash_sck,
  output logic        flash_cs_n,
  output logic        flash_mosi,
  input  logic        flash_miso,
  output logic        busy,
  output logic        done,
  output logic        timeout
);
  localparam int DW     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int GAP_T  = 2 * GAP_SCK;
  localparam int GW     = $clog2(GAP_T + 1);
  localparam int PW     = $clog2(POLL_LIMIT + 1);
  localparam logic [23:0] SEC_MASK = ~((24'd1 << SECTOR_LOG2) - 24'd1);
  localparam logic [23:0] BLK_MASK = ~((24'd1 << BLOCK_LOG2) - 24'd1);
  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [7:0] OP_SEC  = 8'h20;
  localparam logic [7:0] OP_BLK  = 8'h52;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;
  typedef enum logic [1:0] {P_WEN, P_ERASE, P_POLL} ph_t;

  st_t         st;
  ph_t         ph;
  logic [DW-1:0] div;
  logic [GW-1:0] gapc;
  logic [PW-1:0] pc;
  logic [5:0]  bitn, len;
  logic [31:0] sr, eword;
  logic [7:0]  rx;
  logic        sck, cs_n;

  wire tick = (div == DW'(HALF_DIV - 1));

  assign flash_sck  = sck;
  assign flash_cs_n = cs_n;
  assign flash_mosi = !cs_n && sr[31];
  assign busy       = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= P_WEN;
      div     <= '0;
      gapc    <= '0;
      pc      <= '0;
      bitn    <= '0;
      len     <= '0;
      sr      <= '0;
      eword   <= '0;
      rx      <= '0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        div <= '0;
        if (start) begin
          eword   <= erase_big ? {OP_BLK, erase_addr & BLK_MASK}
                               : {OP_SEC, erase_addr & SEC_MASK};
          sr      <= {OP_WEN, 24'h0};
          len     <= 6'd8;
          bitn    <= '0;
          ph      <= P_WEN;
          timeout <= 1'b0;
          cs_n    <= 1'b0;
          sck     <= 1'b0;
          st      <= S_SHIFT;
        end
      end else begin
        div <= tick ? '0 : div + DW'(1);
        if (tick) begin
          case (st)
            S_SHIFT: begin
              if (!sck) begin
                sck <= 1'b1;
                rx  <= {rx[6:0], flash_miso};
              end else begin
                sck <= 1'b0;
                sr  <= {sr[30:0], 1'b0};
                if (bitn == len - 6'd1) begin
                  cs_n <= 1'b1;
                  gapc <= '0;
                  st   <= S_GAP;
                end else begin
                  bitn <= bitn + 6'd1;
                end
              end
            end
            S_GAP: begin
              if (gapc == GW'(GAP_T - 1)) begin
                gapc <= '0;
                bitn <= '0;
                case (ph)
                  P_WEN: begin
                    sr   <= eword;
                    len  <= 6'd32;
                    ph   <= P_ERASE;
                    cs_n <= 1'b0;
                    st   <= S_SHIFT;
                  end
                  P_ERASE: begin
                    sr   <= {OP_STAT, 24'h0};
                    len  <= 6'd16;
                    ph   <= P_POLL;
                    pc   <= '0;
                    cs_n <= 1'b0;
                    st   <= S_SHIFT;
                  end
                  default: begin
                    if (!rx[0]) begin
                      done <= 1'b1;
                      st   <= S_IDLE;
                    end else if (pc == PW'(POLL_LIMIT - 1)) begin
                      timeout <= 1'b1;
                      done    <= 1'b1;
                      st      <= S_IDLE;
                    end else begin
                      pc   <= pc + PW'(1);
                      sr   <= {OP_STAT, 24'h0};
                      cs_n <= 1'b0;
                      st   <= S_SHIFT;
                    end
                  end
                endcase
              end else begin
                gapc <= gapc + GW'(1);
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

module flash_erase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic timeout,
  input logic sck,
  input logic cs_n,
  input logic mosi
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck));
  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !cs_n));
  p_done_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_sck_low_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_mosi_steady_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && $past(sck)) |-> $stable(mosi));
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> (busy || done));
  p_timeout_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind flash_erase_seq flash_erase_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .timeout(timeout), .sck(flash_sck), .cs_n(flash_cs_n), .mosi(flash_mosi)
);

// File: tb/tb_flash_erase_seq.sv
`timescale 1ns/1ps
module tb_flash_erase_seq;
  localparam int HALF = 2;
  localparam int GAPS = 2;
  localparam int LIM  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic erase_big = 1'b0;
  logic [23:0] erase_addr = '0;
  logic sck, cs_n, mosi, busy, done, timeout;
  logic miso = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_erase_seq #(.HALF_DIV(HALF), .GAP_SCK(GAPS), .POLL_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .erase_big(erase_big),
    .erase_addr(erase_addr), .flash_sck(sck), .flash_cs_n(cs_n),
    .flash_mosi(mosi), .flash_miso(miso), .busy(busy), .done(done),
    .timeout(timeout));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int          exp_len[$];
  logic [31:0] exp_bits[$];

  int busy_cfg  = 0;
  int busy_left = 0;
  bit in_op     = 0;
  bit seen_end  = 0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;
  logic [31:0] cap = '0;
  int nb = 0, hi_cnt = 0, rise_cnt = 0;

  always @(negedge clk) begin
    logic [7:0] stat;
    stat = {7'b1010100, busy_left != 0};
    if (cs_n) hi_cnt++;
    rise_cnt++;
    if (!cs_n && prev_cs) begin
      if (in_op && seen_end)
        chk(hi_cnt >= 2 * GAPS * HALF, "R6", "gap clocks", hi_cnt, 2 * GAPS * HALF);
      hi_cnt = 0; cap = '0; nb = 0;
    end
    if (!cs_n && sck && !prev_sck) begin
      if (nb > 0) chk(rise_cnt == 2 * HALF, "R7", "sck period clocks", rise_cnt, 2 * HALF);
      rise_cnt = 0;
      cap = {cap[30:0], mosi};
      nb++;
    end
    if (!cs_n && !sck && prev_sck && nb >= 8 && nb < 16) miso <= stat[15 - nb];
    if (cs_n && !prev_cs) begin
      seen_end = 1;
      if (exp_len.size() == 0) begin
        chk(0, "R8", "unexpected frame bits", nb, 0);
      end else begin
        int l;
        logic [31:0] b, m;
        l = exp_len.pop_front();
        b = exp_bits.pop_front();
        m = (l == 32) ? 32'hFFFF_FFFF : ((32'd1 << l) - 32'd1);
        chk(nb == l, "R3", "frame length", nb, l);
        chk((cap & m) == b, "R3", "frame content", cap & m, b);
      end
      if (nb == 32) busy_left = busy_cfg;
      else if (nb == 16 && busy_left > 0) busy_left--;
      miso <= 1'b0;
    end
    prev_sck = sck;
    prev_cs  = cs_n;
  end

  task automatic run_op(input bit big, input logic [23:0] a, input int nbusy,
                        input bit spur, input bit exp_to);
    logic [23:0] ma;
    int npoll, wait_n, lows;
    ma = big ? (a & 24'hFF8000) : (a & 24'hFFF000);
    exp_len.push_back(8);   exp_bits.push_back(32'h06);
    exp_len.push_back(32);  exp_bits.push_back({big ? 8'h52 : 8'h20, ma});
    npoll = exp_to ? LIM : nbusy + 1;
    for (int i = 0; i < npoll; i++) begin
      exp_len.push_back(16); exp_bits.push_back(32'h0500);
    end
    busy_cfg = nbusy; seen_end = 0; in_op = 1;
    @(negedge clk);
    start = 1; erase_big = big; erase_addr = a;
    @(negedge clk);
    start = 0;
    chk(busy && !cs_n, "R2", "frame opened after start", {busy, cs_n}, 2'b10);
    chk(timeout == 0, "R9", "timeout cleared by start", timeout, 0);
    if (spur) begin
      repeat (20) @(negedge clk);
      start = 1; erase_big = !big; erase_addr = 24'hABCDEF;
      @(negedge clk);
      start = 0;
      chk(busy == 1, "R8", "busy after ignored start", busy, 1);
    end
    wait_n = 0;
    while (!done && wait_n < 20000) begin
      @(negedge clk); wait_n++;
    end
    chk(done == 1, "R5", "done seen", done, 1);
    chk(busy == 0, "R5", "busy low with done", busy, 0);
    chk(timeout == exp_to, "R9", "timeout flag", timeout, exp_to);
    chk(exp_len.size() == 0, "R4", "status frames left unsent", exp_len.size(), 0);
    @(negedge clk);
    chk(done == 0, "R10", "done width", done, 0);
    in_op = 0;
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!cs_n) lows++;
    end
    chk(lows == 0, "R8", "frames after done", lows, 0);
    chk(timeout == exp_to, "R9", "timeout held", timeout, exp_to);
    exp_len.delete(); exp_bits.delete();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R5 watchdog: done actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1 && sck == 0, "R1", "idle pins", {cs_n, sck}, 2'b10);
    chk(busy == 0 && done == 0 && timeout == 0, "R1", "idle flags",
        {busy, done, timeout}, 3'b000);
    run_op(1'b0, 24'h123ABC, 2, 1'b0, 1'b0);
    run_op(1'b1, 24'h7FFFFF, 0, 1'b0, 1'b0);
    run_op(1'b0, 24'h00_5FFF, 1, 1'b1, 1'b0);
    run_op(1'b1, 24'h3C_4321, 1000, 1'b0, 1'b1);
    run_op(1'b1, 24'h00_8001, 3, 1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule